// File: doc/BRIEF.md
# Add/Subtract ALU with Status Flags

This block is a purely combinational integer adder/subtractor for 8-, 16- or 32-bit operands. One operation code picks among plain add, add with the incoming carry, plain subtract, subtract with the incoming carry as a borrow, increment, decrement, compare and exchange-add. A size code picks the operand width; both operands always use that width. The block returns the result, a second writeback value used only by exchange-add, two write enables, and six status flags: carry, overflow, sign, zero, nibble carry and low-byte parity.

All outputs follow the inputs in the same cycle. The block holds no state and has no clock, so there is no handshake and no back-pressure: the surrounding execute stage samples the outputs whenever it chooses. Per-operation rules decide whether the carry flag is recomputed or passed through, and whether each writeback port is enabled.

Top module: `addsub_flag_alu`

## Requirements
- R1: Operation codes on op_i are 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 increment, 5 decrement, 6 compare, 7 exchange-add. Size codes on size_i are 0 for 8 bits, 1 for 16 bits, 2 and 3 for 32 bits. Operand bits above the selected width are ignored and result bits above it are zero.
- R2: Add gives dst + src; add-with-carry gives dst + src + carry_i, both modulo 2^width.
- R3: Subtract gives dst - src; subtract-with-borrow gives dst - src - carry_i, both modulo 2^width.
- R4: For add, add-with-carry and exchange-add, cf_o is the carry out of the selected width's top bit; for subtract, subtract-with-borrow and compare it is 1 exactly when a borrow occurs (for compare: dst < src as unsigned).
- R5: of_o is 1 when the signed result at the selected width overflows or underflows.
- R6: sf_o equals the top bit of the result at the selected width; zf_o is 1 when the sized result is all zeros.
- R7: af_o is 1 on a carry out of bit 3 (add forms) or a borrow out of bit 3 (subtract forms).
- R8: pf_o is 1 when res_o[7:0] holds an even number of one bits and 0 when odd, at every width.
- R9: Increment and decrement compute dst + 1 and dst - 1 and set overflow, sign, zero, nibble carry and parity as that add or subtract would, while cf_o equals carry_i.
- R10: Compare sets all six flags as subtract does, res_o shows the difference, and res_we_o is 0.
- R11: Exchange-add drives res_o = dst + src with add flags, swap_o = the sized old dst, and swap_we_o = 1; every other operation drives swap_we_o = 0.
- R12: res_we_o is 1 for every operation except compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 3 | Operation code |
| size_i | input | 2 | Operand width code |
| dst_i | input | 32 | Destination operand |
| src_i | input | 32 | Source operand |
| carry_i | input | 1 | Incoming carry flag |
| res_o | output | 32 | Sized result, zero above the width |
| res_we_o | output | 1 | Destination writeback enable |
| swap_o | output | 32 | Value for the source operand on exchange-add |
| swap_we_o | output | 1 | Source writeback enable |
| cf_o | output | 1 | Carry / borrow flag |
| of_o | output | 1 | Signed overflow flag |
| sf_o | output | 1 | Sign flag |
| zf_o | output | 1 | Zero flag |
| af_o | output | 1 | Carry or borrow out of bit 3 |
| pf_o | output | 1 | Even parity of result bits 7..0 |

## Verification
The hardest cases to expose are those where a flag taken at the wrong bit position or the wrong carry policy happens to agree with the correct one. The stimulus therefore uses operands whose bits above the selected width are set, so a flag taken at bit 31 instead of bit 15 differs, and an increment of an all-ones byte and a decrement of the most negative word with carry_i set opposite to the carry a plain add or subtract would produce. Subtract-with-borrow is driven with the borrow in set, and the unused size code 3 is given a value whose result differs between 8 and 32 bits.

// File: rtl/aluf_pkg.sv
package aluf_pkg;
  localparam int DATA_W = 32;
  localparam int NUM_SZ = 3;
  localparam int NIB_W  = 4;
  localparam int PAR_W  = 8;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADC  = 3'd1,
    OP_SUB  = 3'd2,
    OP_SBB  = 3'd3,
    OP_INC  = 3'd4,
    OP_DEC  = 3'd5,
    OP_CMP  = 3'd6,
    OP_XADD = 3'd7
  } aluf_op_e;

  typedef enum logic [1:0] {
    SZ_8   = 2'd0,
    SZ_16  = 2'd1,
    SZ_32  = 2'd2,
    SZ_32B = 2'd3
  } aluf_sz_e;

  // width in bits of lane k (8 << k)
  function automatic int lane_bits(input int k);
    return 8 << k;
  endfunction

  typedef struct packed {
    logic is_sub;
    logic one_src;
    logic cin;
    logic keep_cf;
    logic res_we;
    logic swap_we;
  } aluf_ctl_t;
endpackage

// File: rtl/aluf_width_sel.sv
module aluf_width_sel
  import aluf_pkg::*;
(
  input  logic [1:0]        size_i,
  output logic [NUM_SZ-1:0] lane_hot_o,
  output logic [DATA_W-1:0] mask_o
);
  logic [NUM_SZ-1:0] hot;
  logic [DATA_W-1:0] lane_mask [NUM_SZ];

  always_comb begin
    hot = '0;
    case (aluf_sz_e'(size_i))
      SZ_8:    hot[0] = 1'b1;
      SZ_16:   hot[1] = 1'b1;
      default: hot[NUM_SZ-1] = 1'b1;
    endcase
  end

  for (genvar k = 0; k < NUM_SZ; k++) begin : g_lane
    localparam int LW = lane_bits(k);
    always_comb begin
      lane_mask[k] = '0;
      lane_mask[k][LW-1:0] = '1;
      if (!hot[k]) lane_mask[k] = '0;
    end
  end

  always_comb begin
    mask_o = '0;
    for (int k = 0; k < NUM_SZ; k++) mask_o = mask_o | lane_mask[k];
  end

  assign lane_hot_o = hot;
endmodule

// File: rtl/aluf_opdec.sv
module aluf_opdec
  import aluf_pkg::*;
(
  input  logic [2:0] op_i,
  input  logic       carry_i,
  output aluf_ctl_t  ctl_o
);
  always_comb begin
    ctl_o = '{is_sub: 1'b0, one_src: 1'b0, cin: 1'b0, keep_cf: 1'b0,
              res_we: 1'b1, swap_we: 1'b0};
    case (aluf_op_e'(op_i))
      OP_ADD:  ;
      OP_ADC:  ctl_o.cin = carry_i;
      OP_SUB:  begin ctl_o.is_sub = 1'b1; ctl_o.cin = 1'b1; end
      OP_SBB:  begin ctl_o.is_sub = 1'b1; ctl_o.cin = ~carry_i; end
      OP_INC:  begin ctl_o.one_src = 1'b1; ctl_o.keep_cf = 1'b1; end
      OP_DEC:  begin
        ctl_o.is_sub = 1'b1; ctl_o.cin = 1'b1;
        ctl_o.one_src = 1'b1; ctl_o.keep_cf = 1'b1;
      end
      OP_CMP:  begin ctl_o.is_sub = 1'b1; ctl_o.cin = 1'b1; ctl_o.res_we = 1'b0; end
      OP_XADD: ctl_o.swap_we = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/aluf_addcore.sv
module aluf_addcore
  import aluf_pkg::*;
(
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  input  logic [NUM_SZ-1:0] lane_hot_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o,
  output logic              cmsb_o,
  output logic              cnib_o
);
  logic [DATA_W:0]   sum_ext;
  logic [DATA_W:0]   c_into;
  logic [NUM_SZ-1:0] cout_lane;
  logic [NUM_SZ-1:0] cmsb_lane;

  assign sum_ext = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_i};
  assign c_into  = {sum_ext[DATA_W], sum_ext[DATA_W-1:0] ^ a_i ^ b_i};

  for (genvar k = 0; k < NUM_SZ; k++) begin : g_tap
    localparam int LW = lane_bits(k);
    assign cout_lane[k] = c_into[LW]   & lane_hot_i[k];
    assign cmsb_lane[k] = c_into[LW-1] & lane_hot_i[k];
  end

  assign sum_o  = sum_ext[DATA_W-1:0] & mask_i;
  assign cout_o = |cout_lane;
  assign cmsb_o = |cmsb_lane;
  assign cnib_o = c_into[NIB_W];
endmodule

// File: rtl/aluf_flags.sv
module aluf_flags
  import aluf_pkg::*;
(
  input  logic [DATA_W-1:0] sum_i,
  input  logic [NUM_SZ-1:0] lane_hot_i,
  input  logic              cout_i,
  input  logic              cmsb_i,
  input  logic              cnib_i,
  input  logic              is_sub_i,
  input  logic              keep_cf_i,
  input  logic              carry_i,
  output logic              cf_o,
  output logic              of_o,
  output logic              sf_o,
  output logic              zf_o,
  output logic              af_o,
  output logic              pf_o
);
  logic [NUM_SZ-1:0] top_bit;

  for (genvar k = 0; k < NUM_SZ; k++) begin : g_sign
    localparam int LW = lane_bits(k);
    assign top_bit[k] = sum_i[LW-1] & lane_hot_i[k];
  end

  // a subtract runs as add of the inverted operand: borrow = no carry
  assign cf_o = keep_cf_i ? carry_i : (cout_i ^ is_sub_i);
  assign of_o = cmsb_i ^ cout_i;
  assign sf_o = |top_bit;
  assign zf_o = ~|sum_i;
  assign af_o = cnib_i ^ is_sub_i;
  assign pf_o = ~^sum_i[PAR_W-1:0];
endmodule

// File: rtl/addsub_flag_alu.sv
module addsub_flag_alu
  import aluf_pkg::*;
(
  input  logic [2:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] res_o,
  output logic              res_we_o,
  output logic [DATA_W-1:0] swap_o,
  output logic              swap_we_o,
  output logic              cf_o,
  output logic              of_o,
  output logic              sf_o,
  output logic              zf_o,
  output logic              af_o,
  output logic              pf_o
);
  logic [NUM_SZ-1:0] lane_hot;
  logic [DATA_W-1:0] mask;
  aluf_ctl_t         ctl;
  logic [DATA_W-1:0] a_op, b_raw, b_op, sum;
  logic              cout, cmsb, cnib;

  aluf_width_sel u_width (
    .size_i     (size_i),
    .lane_hot_o (lane_hot),
    .mask_o     (mask)
  );

  aluf_opdec u_dec (
    .op_i    (op_i),
    .carry_i (carry_i),
    .ctl_o   (ctl)
  );

  assign a_op  = dst_i & mask;
  assign b_raw = ctl.one_src ? DATA_W'(1) : src_i;
  assign b_op  = (ctl.is_sub ? ~b_raw : b_raw) & mask;

  aluf_addcore u_add (
    .a_i        (a_op),
    .b_i        (b_op),
    .cin_i      (ctl.cin),
    .lane_hot_i (lane_hot),
    .mask_i     (mask),
    .sum_o      (sum),
    .cout_o     (cout),
    .cmsb_o     (cmsb),
    .cnib_o     (cnib)
  );

  aluf_flags u_flg (
    .sum_i      (sum),
    .lane_hot_i (lane_hot),
    .cout_i     (cout),
    .cmsb_i     (cmsb),
    .cnib_i     (cnib),
    .is_sub_i   (ctl.is_sub),
    .keep_cf_i  (ctl.keep_cf),
    .carry_i    (carry_i),
    .cf_o       (cf_o),
    .of_o       (of_o),
    .sf_o       (sf_o),
    .zf_o       (zf_o),
    .af_o       (af_o),
    .pf_o       (pf_o)
  );

  assign res_o     = sum;
  assign res_we_o  = ctl.res_we;
  assign swap_o    = a_op;
  assign swap_we_o = ctl.swap_we;
endmodule

module addsub_flag_alu_chk
  import aluf_pkg::*;
(
  input logic [2:0]        op_i,
  input logic [1:0]        size_i,
  input logic [DATA_W-1:0] dst_i,
  input logic              carry_i,
  input logic [DATA_W-1:0] res_o,
  input logic              res_we_o,
  input logic [DATA_W-1:0] swap_o,
  input logic              swap_we_o,
  input logic              cf_o,
  input logic              sf_o,
  input logic              zf_o,
  input logic              pf_o
);
  always_comb begin
    a_r10_cmp_no_write: assert (!(op_i == OP_CMP) || !res_we_o);
    a_r12_write_enable: assert ((op_i == OP_CMP) || res_we_o);
    a_r9_keep_carry: assert (!(op_i == OP_INC || op_i == OP_DEC) || (cf_o == carry_i));
    a_r11_swap_only_xadd: assert (swap_we_o == (op_i == OP_XADD));
    a_r11_swap_low_byte: assert (!swap_we_o || (swap_o[7:0] == dst_i[7:0]));
    a_r6_zero_flag: assert (zf_o == (res_o == '0));
    a_r8_parity: assert (pf_o == ~^res_o[7:0]);
    a_r1_upper_zero: assert (size_i[1] || (res_o[31:16] == '0));
    a_r6_sign_byte: assert (size_i != SZ_8 || (sf_o == res_o[7] && res_o[15:8] == '0));
  end
endmodule

bind addsub_flag_alu addsub_flag_alu_chk chk_i (
  .op_i      (op_i),
  .size_i    (size_i),
  .dst_i     (dst_i),
  .carry_i   (carry_i),
  .res_o     (res_o),
  .res_we_o  (res_we_o),
  .swap_o    (swap_o),
  .swap_we_o (swap_we_o),
  .cf_o      (cf_o),
  .sf_o      (sf_o),
  .zf_o      (zf_o),
  .pf_o      (pf_o)
);

// File: tb/addsub_flag_alu_tb_top.sv
module addsub_flag_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op;
  logic [1:0]  size;
  logic [31:0] dst, src;
  logic        cin;
  logic [31:0] res, swap;
  logic        res_we, swap_we, cf, of, sf, zf, af, pf;
  int          n_chk = 0;
  int          n_fail = 0;
  int          cyc = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  addsub_flag_alu dut_i (
    .op_i (op), .size_i (size), .dst_i (dst), .src_i (src), .carry_i (cin),
    .res_o (res), .res_we_o (res_we), .swap_o (swap), .swap_we_o (swap_we),
    .cf_o (cf), .of_o (of), .sf_o (sf), .zf_o (zf), .af_o (af), .pf_o (pf)
  );

  // {op, size, carry_in, dst, src, exp_res, exp flags cf,of,sf,zf,af,pf}
  localparam logic [107:0] VEC [15] = '{
    {3'd0, 2'd0, 1'b0, 32'h00000012, 32'h00000002, 32'h00000014, 6'b000001},
    {3'd0, 2'd0, 1'b0, 32'h0000007F, 32'h00000001, 32'h00000080, 6'b011010},
    {3'd0, 2'd0, 1'b0, 32'h000000FF, 32'h00000001, 32'h00000000, 6'b100111},
    {3'd1, 2'd1, 1'b1, 32'h0000FFFF, 32'h00000000, 32'h00000000, 6'b100111},
    {3'd2, 2'd0, 1'b0, 32'h00000000, 32'h00000001, 32'h000000FF, 6'b101011},
    {3'd3, 2'd1, 1'b1, 32'h00008000, 32'h00000000, 32'h00007FFF, 6'b010011},
    {3'd4, 2'd0, 1'b0, 32'h000000FF, 32'h00000000, 32'h00000000, 6'b000111},
    {3'd5, 2'd2, 1'b1, 32'h80000000, 32'h00000000, 32'h7FFFFFFF, 6'b110011},
    {3'd6, 2'd1, 1'b0, 32'h00000003, 32'h00000005, 32'h0000FFFE, 6'b101010},
    {3'd6, 2'd2, 1'b0, 32'h12345678, 32'h12345678, 32'h00000000, 6'b000101},
    {3'd7, 2'd0, 1'b0, 32'h00000012, 32'h00000002, 32'h00000014, 6'b000001},
    {3'd0, 2'd1, 1'b0, 32'hABCD7FFF, 32'hFFFF0001, 32'h00008000, 6'b011011},
    {3'd0, 2'd2, 1'b0, 32'h80000000, 32'h80000000, 32'h00000000, 6'b110101},
    {3'd2, 2'd0, 1'b0, 32'h00000080, 32'h00000001, 32'h0000007F, 6'b010010},
    {3'd0, 2'd3, 1'b0, 32'h0000FFFF, 32'h00000001, 32'h00010000, 6'b000011}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] o, input logic [1:0] s, input logic c,
                       input logic [31:0] d, input logic [31:0] x);
    @(posedge clk);
    op = o; size = s; cin = c; dst = d; src = x;
    #5;
  endtask

  function automatic logic [5:0] flags();
    return {cf, of, sf, zf, af, pf};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<5000", cyc);
      finish_run();
    end
  end

  initial begin
    op = 3'd0; size = 2'd0; cin = 1'b0; dst = '0; src = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #5;
    // reset state: all-zero add at 8 bits
    check("R6 reset res", res, 32'h0);
    check("R8 reset flags", {26'd0, flags()}, {26'd0, 6'b000101});
    check("R11 reset swap_we", {31'd0, swap_we}, 32'd0);

    for (int i = 0; i < 15; i++) begin
      logic [107:0] v;
      logic [2:0]   vo;
      v  = VEC[i];
      vo = v[107:105];
      apply(vo, v[104:103], v[102], v[101:70], v[69:38]);
      check($sformatf("R2 R3 R1 vec%0d result", i), res, v[37:6]);
      check($sformatf("R4 R5 R6 R7 R8 R9 vec%0d flags", i), {26'd0, flags()}, {26'd0, v[5:0]});
      check($sformatf("R12 R10 vec%0d res_we", i), {31'd0, res_we}, {31'd0, vo != 3'd6});
      check($sformatf("R11 vec%0d swap_we", i), {31'd0, swap_we}, {31'd0, vo == 3'd7});
    end

    // R11: swapped value is old destination
    apply(3'd7, 2'd0, 1'b0, 32'h00000012, 32'h00000002);
    check("R11 xadd swap value", swap, 32'h00000012);
    apply(3'd7, 2'd1, 1'b1, 32'hFFFF1234, 32'h00000001);
    check("R11 xadd sized swap", swap, 32'h00001234);
    check("R11 xadd ignores carry_in", res, 32'h00001235);

    // R9: increment with carry_i set where add would not carry
    apply(3'd4, 2'd1, 1'b1, 32'h00001233, 32'h0000FFFF);
    check("R9 inc result ignores src", res, 32'h00001234);
    check("R9 inc keeps carry", {31'd0, cf}, 32'd1);
    apply(3'd5, 2'd0, 1'b0, 32'h00000000, 32'h0);
    check("R9 dec wrap result", res, 32'h000000FF);
    check("R9 dec keeps carry clear", {31'd0, cf}, 32'd0);

    // R2: add-with-carry with carry clear behaves as add
    apply(3'd1, 2'd0, 1'b0, 32'h0000000F, 32'h00000001);
    check("R2 adc no carry", res, 32'h00000010);
    check("R7 adc nibble carry", {31'd0, af}, 32'd1);

    // R3: subtract-with-borrow, all-ones source and borrow in
    apply(3'd3, 2'd0, 1'b1, 32'h00000005, 32'h000000FF);
    check("R3 sbb max src", res, 32'h00000005);
    check("R4 sbb max src borrow", {31'd0, cf}, 32'd1);

    // R10: compare with dst > src unsigned, signed overflow
    apply(3'd6, 2'd0, 1'b1, 32'h00000080, 32'h00000001);
    check("R10 cmp flags", {26'd0, flags()}, {26'd0, 6'b010010});

    // R5: 16-bit overflow taken at bit 15, not bit 31
    apply(3'd0, 2'd1, 1'b0, 32'h00004000, 32'h00004000);
    check("R5 of at width", {31'd0, of}, 32'd1);
    check("R6 sign at width", {31'd0, sf}, 32'd1);

    finish_run();
  end
endmodule